// File: doc/BRIEF.md
# Sub-word Load Unit with Alignment Trap

This block executes signed byte and signed halfword loads for a simple in-order pipeline. When a load is issued it adds the sign-extended 16-bit displacement to the base operand to form a byte address. It then checks that address against the access size. If the address is legal it sends one read request to a translated memory port. When the response comes back it picks the addressed lane out of the returned word, sign-extends it and writes it to the destination register.

A halfword load at an odd address is not sent to memory. Instead the unit raises an address-error-on-load pulse that carries the faulting address. A response that reports a translation fault ends the load without a register write. Register 0 is never written. While a load is outstanding the unit is busy and ignores new issues. Lane selection follows an endianness fixed by a parameter. The requirements below assume the default, little-endian.

Top module: `load_unit`

## Requirements
- R1: One cycle after an accepted issue, `mem_req` is high for exactly one cycle and `mem_addr` equals `base + sign_extend(offset)`, computed modulo 2^32.
- R2: A byte load (`issue_half`=0) is legal at every address. Its result is bits [8*a+7:8*a] of `mem_rdata`, where a = address[1:0], sign-extended from bit 7 to 32 bits.
- R3: A halfword load (`issue_half`=1) at an even address returns bits [16*h+15:16*h] of `mem_rdata`, where h = address[1], sign-extended from bit 15 to 32 bits.
- R4: A halfword load at an odd address pulses `ade_exc` for one cycle, one cycle after issue, with `exc_addr` equal to the address. It raises no `mem_req`, no `wb_en`, and the unit does not become busy.
- R5: A response with `mem_fault`=1 ends the load with no `wb_en` and returns the unit to idle.
- R6: A load whose destination is register 0 never raises `wb_en`.
- R7: One cycle after a fault-free response, `wb_en` pulses for one cycle. `wb_reg` carries the destination captured at issue, and `wb_data` carries the result.
- R8: While `busy` is high, `issue_valid` is ignored. No new request is made, and the pending load completes with its own destination and size.
- R9: During and right after reset, `mem_req`, `ade_exc`, `wb_en` and `busy` are low.
- R10: A `mem_rvalid` that arrives while the unit is idle produces no `wb_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Load issue strobe, accepted when not busy |
| issue_half | input | 1 | Access size: 0 = byte, 1 = halfword |
| issue_base | input | 32 | Base operand |
| issue_offset | input | 16 | Signed displacement |
| issue_rt | input | 5 | Destination register index |
| busy | output | 1 | A load awaits its response |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 32 | Byte address of the request |
| mem_rvalid | input | 1 | Read response strobe |
| mem_rdata | input | 32 | Returned word |
| mem_fault | input | 1 | Translation failed for this response |
| ade_exc | output | 1 | Address-error-on-load pulse |
| exc_addr | output | 32 | Faulting address |
| wb_en | output | 1 | Register write strobe |
| wb_reg | output | 5 | Register write index |
| wb_data | output | 32 | Register write value |

## Verification
The captured lane offset or size may be corrupted between issue and response. That shows up as a wrong `wb_data` in the cycle after `mem_rvalid`, so a sweep over every lane with asymmetric data patterns exposes it within a single load. A corrupted state register shows up at the ports in one of two ways. It may leave `busy` stuck, so that later issues raise no `mem_req` one cycle after issue. Or it may accept a second issue while a load is pending, which raises a stray `mem_req`. Any error in the alignment test shows as `ade_exc` and `mem_req` disagreeing in the first cycle after issue.

// File: rtl/lu_pkg.sv
package lu_pkg;
  typedef enum logic {
    LU_IDLE = 1'b0,
    LU_WAIT = 1'b1
  } lu_state_e;
endpackage

// File: rtl/lu_agen.sv
module lu_agen #(
  parameter int DATA_W = 32,
  parameter int OFFS_W = 16
) (
  input  logic [DATA_W-1:0] base,
  input  logic [OFFS_W-1:0] offset,
  input  logic              half,
  output logic [DATA_W-1:0] ea,
  output logic              misaligned
);
  localparam int EXT_W = DATA_W - OFFS_W;

  logic [DATA_W-1:0] offs_ext;

  always_comb begin
    offs_ext   = {{EXT_W{offset[OFFS_W-1]}}, offset};
    ea         = base + offs_ext;
    misaligned = half & ea[0];
  end
endmodule

// File: rtl/lu_extract.sv
module lu_extract #(
  parameter int DATA_W     = 32,
  parameter bit BIG_ENDIAN = 1'b0
) (
  input  logic [DATA_W-1:0]             rdata,
  input  logic [$clog2(DATA_W/8)-1:0]   lane,
  input  logic                          half,
  output logic [DATA_W-1:0]             value
);
  localparam int LANES = DATA_W / 8;
  localparam int LAW   = $clog2(LANES);
  localparam int HAW   = (LAW > 1) ? LAW - 1 : 1;

  logic [LAW-1:0] bidx;
  logic [HAW-1:0] hidx;
  logic [7:0]     byte_v;
  logic [15:0]    half_v;

  generate
    if (BIG_ENDIAN) begin : g_big
      always_comb begin
        bidx = LAW'(LANES - 1) - lane;
        hidx = HAW'(LANES / 2 - 1) - HAW'(lane >> 1);
      end
    end else begin : g_little
      always_comb begin
        bidx = lane;
        hidx = HAW'(lane >> 1);
      end
    end
  endgenerate

  always_comb begin
    byte_v = rdata[8*bidx +: 8];
    half_v = rdata[16*hidx +: 16];
    if (half) value = {{(DATA_W-16){half_v[15]}}, half_v};
    else      value = {{(DATA_W-8){byte_v[7]}}, byte_v};
  end
endmodule

// File: rtl/lu_ctrl.sv
module lu_ctrl
  import lu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_AW = 5
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        issue_valid,
  input  logic                        issue_half,
  input  logic [REG_AW-1:0]           issue_rt,
  input  logic [DATA_W-1:0]           ea,
  input  logic                        misaligned,
  input  logic                        mem_rvalid,
  input  logic                        mem_fault,
  input  logic [DATA_W-1:0]           ext_value,
  output logic                        busy,
  output logic                        mem_req,
  output logic [DATA_W-1:0]           mem_addr,
  output logic                        ade_exc,
  output logic [DATA_W-1:0]           exc_addr,
  output logic                        wb_en,
  output logic [REG_AW-1:0]           wb_reg,
  output logic [DATA_W-1:0]           wb_data,
  output logic                        pend_half,
  output logic [$clog2(DATA_W/8)-1:0] pend_lane
);
  localparam int LAW = $clog2(DATA_W / 8);

  lu_state_e         state;
  logic [REG_AW-1:0] pend_rt;

  assign busy = (state == LU_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= LU_IDLE;
      mem_req   <= 1'b0;
      mem_addr  <= '0;
      ade_exc   <= 1'b0;
      exc_addr  <= '0;
      wb_en     <= 1'b0;
      wb_reg    <= '0;
      wb_data   <= '0;
      pend_rt   <= '0;
      pend_half <= 1'b0;
      pend_lane <= '0;
    end else begin
      mem_req <= 1'b0;
      ade_exc <= 1'b0;
      wb_en   <= 1'b0;
      case (state)
        LU_IDLE: begin
          if (issue_valid) begin
            if (misaligned) begin
              ade_exc  <= 1'b1;
              exc_addr <= ea;
            end else begin
              mem_req   <= 1'b1;
              mem_addr  <= ea;
              pend_rt   <= issue_rt;
              pend_half <= issue_half;
              pend_lane <= ea[LAW-1:0];
              state     <= LU_WAIT;
            end
          end
        end
        LU_WAIT: begin
          if (mem_rvalid) begin
            state <= LU_IDLE;
            if (!mem_fault && (pend_rt != '0)) begin
              wb_en   <= 1'b1;
              wb_reg  <= pend_rt;
              wb_data <= ext_value;
            end
          end
        end
        default: state <= LU_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/load_unit.sv
module load_unit #(
  parameter int DATA_W     = 32,
  parameter int OFFS_W     = 16,
  parameter int REG_AW     = 5,
  parameter bit BIG_ENDIAN = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_valid,
  input  logic              issue_half,
  input  logic [DATA_W-1:0] issue_base,
  input  logic [OFFS_W-1:0] issue_offset,
  input  logic [REG_AW-1:0] issue_rt,
  output logic              busy,
  output logic              mem_req,
  output logic [DATA_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_fault,
  output logic              ade_exc,
  output logic [DATA_W-1:0] exc_addr,
  output logic              wb_en,
  output logic [REG_AW-1:0] wb_reg,
  output logic [DATA_W-1:0] wb_data
);
  localparam int LAW = $clog2(DATA_W / 8);

  logic [DATA_W-1:0] ea;
  logic              misaligned;
  logic [DATA_W-1:0] ext_value;
  logic              pend_half;
  logic [LAW-1:0]    pend_lane;

  lu_agen #(.DATA_W(DATA_W), .OFFS_W(OFFS_W)) agen_i (
    .base       (issue_base),
    .offset     (issue_offset),
    .half       (issue_half),
    .ea         (ea),
    .misaligned (misaligned)
  );

  lu_extract #(.DATA_W(DATA_W), .BIG_ENDIAN(BIG_ENDIAN)) extract_i (
    .rdata (mem_rdata),
    .lane  (pend_lane),
    .half  (pend_half),
    .value (ext_value)
  );

  lu_ctrl #(.DATA_W(DATA_W), .REG_AW(REG_AW)) ctrl_i (
    .clk         (clk),
    .rst         (rst),
    .issue_valid (issue_valid),
    .issue_half  (issue_half),
    .issue_rt    (issue_rt),
    .ea          (ea),
    .misaligned  (misaligned),
    .mem_rvalid  (mem_rvalid),
    .mem_fault   (mem_fault),
    .ext_value   (ext_value),
    .busy        (busy),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .ade_exc     (ade_exc),
    .exc_addr    (exc_addr),
    .wb_en       (wb_en),
    .wb_reg      (wb_reg),
    .wb_data     (wb_data),
    .pend_half   (pend_half),
    .pend_lane   (pend_lane)
  );
endmodule

// File: rtl/load_unit_chk.sv
module load_unit_chk #(
  parameter int REG_AW = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              issue_valid,
  input logic              busy,
  input logic              mem_req,
  input logic              mem_rvalid,
  input logic              mem_fault,
  input logic              ade_exc,
  input logic              wb_en,
  input logic [REG_AW-1:0] wb_reg
);
  p_req_after_issue_r1: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> ($past(issue_valid) && !$past(busy) && busy));

  p_trap_no_access_r4: assert property (@(posedge clk) disable iff (rst)
    ade_exc |-> (!mem_req && !busy));

  p_fault_no_write_r5: assert property (@(posedge clk) disable iff (rst)
    (busy && mem_rvalid && mem_fault) |=> !wb_en);

  p_zero_reg_r6: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> (wb_reg != '0));

  p_write_after_resp_r7: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> ($past(mem_rvalid) && $past(busy) && !busy));

  p_no_req_when_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && !mem_rvalid) |=> !mem_req);

  p_idle_resp_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    (!busy && mem_rvalid) |=> !wb_en);
endmodule

bind load_unit load_unit_chk #(.REG_AW(REG_AW)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .issue_valid (issue_valid),
  .busy        (busy),
  .mem_req     (mem_req),
  .mem_rvalid  (mem_rvalid),
  .mem_fault   (mem_fault),
  .ade_exc     (ade_exc),
  .wb_en       (wb_en),
  .wb_reg      (wb_reg)
);

// File: tb/load_unit_tb.sv
module load_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issue_valid = 1'b0;
  logic        issue_half = 1'b0;
  logic [31:0] issue_base = '0;
  logic [15:0] issue_offset = '0;
  logic [4:0]  issue_rt = '0;
  logic        busy, mem_req, ade_exc, wb_en;
  logic [31:0] mem_addr, exc_addr, wb_data;
  logic [4:0]  wb_reg;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        mem_fault = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  load_unit dut_i (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_half(issue_half),
    .issue_base(issue_base), .issue_offset(issue_offset), .issue_rt(issue_rt),
    .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .mem_fault(mem_fault), .ade_exc(ade_exc),
    .exc_addr(exc_addr), .wb_en(wb_en), .wb_reg(wb_reg), .wb_data(wb_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expect_val(input logic [31:0] ea, input bit half,
                                             input logic [31:0] d);
    logic [31:0] sh;
    if (half) begin
      sh = d >> (16 * ea[1]);
      return {{16{sh[15]}}, sh[15:0]};
    end
    sh = d >> (8 * ea[1:0]);
    return {{24{sh[7]}}, sh[7:0]};
  endfunction

  task automatic do_load(input logic [31:0] base, input logic [15:0] off, input bit half,
                         input logic [4:0] rt, input logic [31:0] data, input bit fault,
                         input int lat, input bit interfere);
    logic [31:0] ea;
    bit          wr;
    ea = base + {{16{off[15]}}, off};
    @(negedge clk);
    issue_valid = 1'b1; issue_half = half; issue_base = base;
    issue_offset = off; issue_rt = rt;
    @(negedge clk);
    issue_valid = 1'b0;
    if (half && ea[0]) begin
      chk("R4 ade_exc", {31'b0, ade_exc}, 32'd1);
      chk("R4 exc_addr", exc_addr, ea);
      chk("R4 no mem_req", {31'b0, mem_req}, 32'd0);
      chk("R4 not busy", {31'b0, busy}, 32'd0);
      @(negedge clk);
      chk("R4 single pulse", {31'b0, ade_exc}, 32'd0);
      chk("R4 no wb_en", {31'b0, wb_en}, 32'd0);
      return;
    end
    chk("R1 mem_req", {31'b0, mem_req}, 32'd1);
    chk("R1 mem_addr", mem_addr, ea);
    chk("R1 busy", {31'b0, busy}, 32'd1);
    for (int i = 0; i < lat; i++) begin
      if (interfere && i == 0) begin
        issue_valid = 1'b1; issue_half = ~half; issue_rt = rt ^ 5'h1F;
        issue_base = base ^ 32'h5555_0001;
      end
      @(negedge clk);
      issue_valid = 1'b0;
      chk("R8 no request while busy", {31'b0, mem_req}, 32'd0);
      chk("R7 no early wb_en", {31'b0, wb_en}, 32'd0);
    end
    mem_rvalid = 1'b1; mem_rdata = data; mem_fault = fault;
    @(negedge clk);
    mem_rvalid = 1'b0; mem_fault = 1'b0;
    wr = !fault && (rt != 5'd0);
    if (fault) chk("R5 fault suppresses wb_en", {31'b0, wb_en}, 32'd0);
    else if (rt == 5'd0) chk("R6 reg0 suppresses wb_en", {31'b0, wb_en}, 32'd0);
    else chk("R7 wb_en", {31'b0, wb_en}, 32'd1);
    if (wr) begin
      chk("R7 wb_reg", {27'b0, wb_reg}, {27'b0, rt});
      chk(half ? "R3 halfword data" : "R2 byte data", wb_data, expect_val(ea, half, data));
    end
    chk("R5 idle after response", {31'b0, busy}, 32'd0);
    @(negedge clk);
    chk("R7 single wb pulse", {31'b0, wb_en}, 32'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] bases [4];
    logic [15:0] offs [8];
    logic [31:0] datas [3];
    int n;
    bases = '{32'h1000_0000, 32'h0000_0003, 32'hFFFF_FFF0, 32'h7FFF_FFFE};
    offs  = '{16'h0000, 16'h0001, 16'h0002, 16'h0003, 16'hFFFF, 16'hFFFC, 16'h7FFF, 16'h8000};
    datas = '{32'h80FF_7F01, 32'h7F80_01FE, 32'hC3A5_5A3C};
    repeat (3) @(negedge clk);
    chk("R9 mem_req in reset", {31'b0, mem_req}, 32'd0);
    chk("R9 busy in reset", {31'b0, busy}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 wb_en after reset", {31'b0, wb_en}, 32'd0);
    chk("R9 ade_exc after reset", {31'b0, ade_exc}, 32'd0);
    mem_rvalid = 1'b1; mem_rdata = 32'hFFFF_FFFF;
    @(negedge clk);
    mem_rvalid = 1'b0;
    chk("R10 idle response ignored", {31'b0, wb_en}, 32'd0);
    chk("R10 still idle", {31'b0, busy}, 32'd0);
    n = 0;
    foreach (bases[b]) foreach (offs[o]) foreach (datas[d]) for (int h = 0; h < 2; h++) begin
      do_load(bases[b], offs[o], h[0], 5'(n % 32), datas[d], (n % 7) == 3, n % 4, (n % 5) == 2);
      n++;
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule